// File: doc/BRIEF.md
# I2S Balanced Polarity Splitter

This block sits between a stereo I2S source and two multiplexed-input audio DACs. Its job is to let each DAC produce a balanced (true and inverted) output for a single channel. The block runs directly on the incoming bit clock. It recovers each 16-bit two's-complement sample from the stream and forms the exact arithmetic negation of that sample, meaning invert and add one, wrapping at 16 bits. It then re-serialises the samples so that one output line carries the left channel's true/negated pair and another carries the right channel's pair. Each pair occupies the two word-select slots that a DAC would normally use for left and right.

A mode input selects between two output formats:
- **Paired mode** keeps the I2S framing on a single line per channel: one-bit delay after the word-select edge, MSB first.
- **Dual-line mode** serves DACs that have two data inputs. The true and negated words go out at the same moment on separate lines. They are left justified and padded to 18 bits by two trailing zeros, and repeated in both halves of the frame.

A captured input frame is reissued during the following output frame. A one-cycle flag marks every input sample equal to the most negative value, which negates to itself.

Top module: `i2s_balance_splitter`

## Requirements
- R1: The input word select is sampled on the rising bit clock. The sample's MSB is the second bit of each 32-bit half-frame and its LSB is the seventeenth bit. All other bits of the half-frame have no effect on any output. Word select low marks the left sample and high marks the right sample.
- R2: The negated word equals (65536 − x) mod 65536 of the input sample x. A zero input therefore gives zero, and 0x8000 gives 0x8000.
- R3: In paired mode (mode input 0), `l_pos` carries the left true word during the output word-select-low slot and the left negated word during the high slot. `r_pos` does the same with the right sample. Each word sits MSB first at slot bits 2 to 17, and every other slot bit is 0. `l_neg` and `r_neg` stay 0.
- R4: In dual-line mode (mode input 1), `l_pos`/`l_neg` carry the left true/negated word and `r_pos`/`r_neg` carry the right pair. Each word is MSB first at slot bits 1 to 16 of both slots. Bits 17 and 18 (padding) and bits 19 to 32 are 0.
- R5: `ws_out` equals `ws_in` delayed by one bit clock. The data emitted in an output frame, which begins where `ws_out` falls, are the samples of the previous complete input frame.
- R6: The mode input is taken once per frame, on the bit clock where the input word select is first seen low. A change at any other time has no effect before the next such edge.
- R7: `min_flag` is high for exactly one bit clock, in the cycle after the LSB of an input sample equal to 0x8000 was sampled. It is low otherwise.
- R8: Synchronous active-low reset drives every output to 0. The data lines stay 0 until an input frame has been fully captured after the first word-select transition following reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the incoming stream; all state advances on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ws_in | input | 1 | Input word select (0 = left, 1 = right) |
| sd_in | input | 1 | Input serial data |
| mode_in | input | 1 | Output format: 0 = paired, 1 = dual-line |
| ws_out | output | 1 | Output word select, a one-clock delayed copy of ws_in |
| l_pos | output | 1 | Left channel line (paired: true/negated multiplexed; dual: true word) |
| l_neg | output | 1 | Left negated line in dual-line mode, 0 in paired mode |
| r_pos | output | 1 | Right channel line (paired: true/negated multiplexed; dual: true word) |
| r_neg | output | 1 | Right negated line in dual-line mode, 0 in paired mode |
| min_flag | output | 1 | One-cycle pulse when a captured sample equals 0x8000 |

## Verification
Three things fall on the same bit clock at each output frame boundary: the sample pair held for output is reloaded, the mode is latched, and in dual-line mode the MSB of the new word is already driven on the lines. A stale word or mode at that bit would corrupt the first bit of each frame. The stimulus changes the sample values and the mode from frame to frame. It also moves the mode input in the middle of the preceding frame. The first bit of every output slot is then judged against a model that uses only the frame-start mode and the previous frame's samples. A second collision comes from a right sample of 0x8000 whose capture coincides with the emission of the negated left word on the same line. That case checks that the flag pulse and the output stream stay independent.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the balanced polarity splitter.
package sp_pkg;
    // Output line format selected per frame.
    typedef enum logic {
        MODE_PAIRED = 1'b0,
        MODE_DUAL   = 1'b1
    } out_mode_e;
endpackage

// File: rtl/sp_rx.sv
`timescale 1ns/1ps
// Module: sp_rx
// Recovers one W-bit sample per I2S half-frame. Tracks the bit position
// within the half-frame and marks the start of each frame.
// Assumes: half-frames of HALF bit clocks, data sampled on the rising edge,
// MSB one bit after the word-select edge, and HALF > W.
module sp_rx #(
    parameter int W    = 16,
    parameter int HALF = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ws_in,
    input  logic                    sd_in,
    output logic                    frame_start,
    output logic [$clog2(HALF)-1:0] pos_now,
    output logic                    half_now,
    output logic [W-1:0]            cap_l,
    output logic [W-1:0]            cap_r,
    output logic                    got_both,
    output logic                    min_flag
);
    localparam int CW = $clog2(HALF);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic          ws_prev;
    logic          synced;
    logic [CW-1:0] cnt;
    logic [W-2:0]  shreg;
    logic          got_l, got_r;
    logic          ws_chg, sync_now, take;
    logic [W-1:0]  word_now;

    // Decode the current bit position and the capture strobe.
    always_comb begin
        ws_chg      = (ws_in != ws_prev);
        sync_now    = synced | ws_chg;
        pos_now     = ws_chg ? '0 : cnt + 1'b1;
        half_now    = ws_in;
        word_now    = {shreg, sd_in};
        take        = sync_now && (pos_now == CW'(W));
        frame_start = sync_now && ws_chg && !ws_in;
        got_both    = got_l & got_r;
    end

    // Shift, count and latch completed samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev  <= 1'b1;
            synced   <= 1'b0;
            cnt      <= '0;
            shreg    <= '0;
            cap_l    <= '0;
            cap_r    <= '0;
            got_l    <= 1'b0;
            got_r    <= 1'b0;
            min_flag <= 1'b0;
        end else begin
            ws_prev  <= ws_in;
            synced   <= sync_now;
            cnt      <= pos_now;
            shreg    <= word_now[W-2:0];
            min_flag <= take && (word_now == MOST_NEG);
            if (take) begin
                if (ws_in) begin
                    cap_r <= word_now;
                    got_r <= 1'b1;
                end else begin
                    cap_l <= word_now;
                    got_l <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sp_hold.sv
`timescale 1ns/1ps
// Module: sp_hold
// Holds the sample pair and the output mode for one output frame. The
// values are reloaded at each frame start. A bypass makes the newly loaded
// values visible on the loading cycle itself, so the first bit of a frame
// already uses them.
// Assumes: frame_start is a single-cycle strobe from sp_rx.
module sp_hold
    import sp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       got_both,
    input  logic [W-1:0] cap_l,
    input  logic [W-1:0] cap_r,
    input  out_mode_e  mode_in,
    output logic [W-1:0] src_l,
    output logic [W-1:0] src_r,
    output logic       valid_now,
    output out_mode_e  mode_now
);
    logic [W-1:0] hold_l, hold_r;
    logic         valid_q;
    out_mode_e    mode_q;
    logic         load;

    // Choose between the held values and the ones being loaded now.
    always_comb begin
        load      = frame_start && got_both;
        src_l     = load ? cap_l : hold_l;
        src_r     = load ? cap_r : hold_r;
        valid_now = valid_q | load;
        mode_now  = frame_start ? mode_in : mode_q;
    end

    // Register the pair, the valid flag and the mode at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l  <= '0;
            hold_r  <= '0;
            valid_q <= 1'b0;
            mode_q  <= MODE_PAIRED;
        end else begin
            if (frame_start) begin
                mode_q <= mode_in;
            end
            if (load) begin
                hold_l  <= cap_l;
                hold_r  <= cap_r;
                valid_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_tx.sv
`timescale 1ns/1ps
// Module: sp_tx
// Serialiser for the two channels. It selects the output bit for the
// current position from the true word and from its two's-complement
// negation. Outputs are registered.
// Assumes: pos is the position of the input bit sampled on this edge.
// Channel 0 is left and channel 1 is right.
module sp_tx
    import sp_pkg::*;
#(
    parameter int W    = 16,
    parameter int HALF = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0][W-1:0]         src,
    input  logic [$clog2(HALF)-1:0]   pos,
    input  logic                      half,
    input  out_mode_e                 mode_now,
    input  logic                      valid_now,
    output logic [1:0]                p_out,
    output logic [1:0]                n_out
);
    localparam int CW = $clog2(HALF);
    localparam int IW = $clog2(W);

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic [W-1:0]  tru, ng;
        logic [IW-1:0] idx;
        logic          p_d, n_d;

        // Pick the bit for this position, format and slot.
        always_comb begin
            tru = src[ch];
            ng  = ~tru + {{(W-1){1'b0}}, 1'b1};
            idx = '0;
            p_d = 1'b0;
            n_d = 1'b0;
            if (valid_now) begin
                if (mode_now == MODE_PAIRED) begin
                    if (pos >= CW'(1) && pos <= CW'(W)) begin
                        idx = IW'(W - int'(pos));
                        p_d = half ? ng[idx] : tru[idx];
                    end
                end else if (pos < CW'(W)) begin
                    idx = IW'(W - 1 - int'(pos));
                    p_d = tru[idx];
                    n_d = ng[idx];
                end
            end
        end

        // Register the line outputs.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                p_out[ch] <= 1'b0;
                n_out[ch] <= 1'b0;
            end else begin
                p_out[ch] <= p_d;
                n_out[ch] <= n_d;
            end
        end
    end
endmodule

// File: rtl/i2s_balance_splitter.sv
`timescale 1ns/1ps
// Module: i2s_balance_splitter
// Top level. Turns a left/right I2S stream into per-channel true/negated
// word pairs for balanced DAC operation.
// Assumes: clk is the incoming bit clock, and the stream has HALF-bit
// half-frames carrying W-bit samples.
module i2s_balance_splitter
    import sp_pkg::*;
#(
    parameter int W    = 16,
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ws_in,
    input  logic sd_in,
    input  logic mode_in,
    output logic ws_out,
    output logic l_pos,
    output logic l_neg,
    output logic r_pos,
    output logic r_neg,
    output logic min_flag
);
    localparam int CW = $clog2(HALF);

    logic              frame_start;
    logic [CW-1:0]     pos_now;
    logic              half_now;
    logic [W-1:0]      cap_l, cap_r;
    logic              got_both;
    logic [W-1:0]      src_l, src_r;
    logic              valid_now_w;
    out_mode_e         mode_now_w;
    logic [1:0]        p_out, n_out;

    sp_rx #(.W(W), .HALF(HALF)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .ws_in      (ws_in),
        .sd_in      (sd_in),
        .frame_start(frame_start),
        .pos_now    (pos_now),
        .half_now   (half_now),
        .cap_l      (cap_l),
        .cap_r      (cap_r),
        .got_both   (got_both),
        .min_flag   (min_flag)
    );

    sp_hold #(.W(W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .got_both   (got_both),
        .cap_l      (cap_l),
        .cap_r      (cap_r),
        .mode_in    (out_mode_e'(mode_in)),
        .src_l      (src_l),
        .src_r      (src_r),
        .valid_now  (valid_now_w),
        .mode_now   (mode_now_w)
    );

    sp_tx #(.W(W), .HALF(HALF)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      ({src_r, src_l}),
        .pos      (pos_now),
        .half     (half_now),
        .mode_now (mode_now_w),
        .valid_now(valid_now_w),
        .p_out    (p_out),
        .n_out    (n_out)
    );

    // Delay word select by one bit clock to match the registered data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_out <= 1'b0;
        end else begin
            ws_out <= ws_in;
        end
    end

    assign l_pos = p_out[0];
    assign r_pos = p_out[1];
    assign l_neg = n_out[0];
    assign r_neg = n_out[1];
endmodule

// File: rtl/sp_checker.sv
`timescale 1ns/1ps
// Module: sp_checker
// Temporal properties of the splitter's ports, attached by bind.
module sp_checker (
    input logic clk,
    input logic rst_n,
    input logic ws_in,
    input logic ws_out,
    input logic l_pos,
    input logic l_neg,
    input logic r_pos,
    input logic r_neg,
    input logic min_flag,
    input logic mode_now,
    input logic valid_now
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ws_out && !l_pos && !l_neg && !r_pos && !r_neg && !min_flag)); // R8

    AST_WS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ws_out == $past(ws_in))); // R5

    AST_NEG_LINES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_now) == 1'b0) |-> (!l_neg && !r_neg)); // R3

    AST_NO_DATA_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_now) |-> (!l_pos && !l_neg && !r_pos && !r_neg)); // R8

    AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        min_flag |=> !min_flag); // R7
endmodule

bind i2s_balance_splitter sp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ws_in    (ws_in),
    .ws_out   (ws_out),
    .l_pos    (l_pos),
    .l_neg    (l_neg),
    .r_pos    (r_pos),
    .r_neg    (r_neg),
    .min_flag (min_flag),
    .mode_now (mode_now_w),
    .valid_now(valid_now_w)
);

// File: tb/sim_i2s_balance_splitter.sv
`timescale 1ns/1ps
// Bench: behavioural frame model compared against the outputs on every bit clock.
module sim_i2s_balance_splitter;
    localparam int NF = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ws_in = 1'b1;
    logic sd_in = 1'b0;
    logic mode_in = 1'b0;
    logic ws_out, l_pos, l_neg, r_pos, r_neg, min_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [15:0] lw [NF];
    logic [15:0] rw [NF];
    bit          md [NF];

    int prev_k, prev_h, prev_j;

    always #2 clk = ~clk;

    i2s_balance_splitter u0 (
        .clk(clk), .rst_n(rst_n), .ws_in(ws_in), .sd_in(sd_in), .mode_in(mode_in),
        .ws_out(ws_out), .l_pos(l_pos), .l_neg(l_neg), .r_pos(r_pos), .r_neg(r_neg),
        .min_flag(min_flag)
    );

    task automatic chk(string tag, string what, logic act, logic expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s %s frame=%0d half=%0d bit=%0d actual=%b expected=%b",
                     tag, what, prev_k, prev_h, prev_j, act, expv);
        end
    endtask

    // R2: negation model as modular subtraction.
    function automatic logic [15:0] negw(logic [15:0] x);
        return 16'((65536 - int'(x)) % 65536);
    endfunction

    // Compare all outputs against the model for the previously driven bit.
    task automatic compare_prev();
        logic e_lp, e_ln, e_rp, e_rn, e_fl;
        logic [15:0] a, b, na, nb, w;
        string tag;
        e_lp = 0; e_ln = 0; e_rp = 0; e_rn = 0;
        tag = "R8";
        if (prev_k >= 1) begin
            a = lw[prev_k-1]; b = rw[prev_k-1];
            na = negw(a); nb = negw(b);
            if (md[prev_k] == 1'b0) begin
                tag = (prev_h == 0) ? "R1" : "R2";
                if (prev_j >= 1 && prev_j <= 16) begin
                    e_lp = prev_h ? na[16-prev_j] : a[16-prev_j];
                    e_rp = prev_h ? nb[16-prev_j] : b[16-prev_j];
                end
            end else begin
                tag = "R4";
                if (prev_j < 16) begin
                    e_lp = a[15-prev_j]; e_ln = na[15-prev_j];
                    e_rp = b[15-prev_j]; e_rn = nb[15-prev_j];
                end
            end
            if (mode_in != md[prev_k]) tag = "R6";
        end
        w = (prev_k < 0) ? 16'h0 : (prev_h ? rw[prev_k] : lw[prev_k]);
        e_fl = (prev_k >= 0) && (prev_j == 16) && (w == 16'h8000);
        chk("R5", "ws_out", ws_out, 1'(prev_h));
        chk(tag, "l_pos", l_pos, e_lp);
        chk(tag, "r_pos", r_pos, e_rp);
        chk((prev_k >= 1 && md[prev_k] == 1'b0) ? "R3" : tag, "l_neg", l_neg, e_ln);
        chk((prev_k >= 1 && md[prev_k] == 1'b0) ? "R3" : tag, "r_neg", r_neg, e_rn);
        chk("R7", "min_flag", min_flag, e_fl);
    endtask

    task automatic step(int k, int h, int j, logic sd);
        @(negedge clk);
        compare_prev();
        ws_in = 1'(h);
        sd_in = sd;
        prev_k = k; prev_h = h; prev_j = j;
        // R6: next frame's mode is applied in the middle of the current frame.
        if (k >= 0 && h == 0 && j == 20 && k + 1 < NF) mode_in = md[k+1];
    endtask

    initial begin
        lw[0] = 16'h0000; rw[0] = 16'h0000;
        lw[1] = 16'h0001; rw[1] = 16'hFFFF;
        lw[2] = 16'h7FFF; rw[2] = 16'h8000;
        lw[3] = 16'h8000; rw[3] = 16'h7FFF;
        lw[4] = 16'hFFFF; rw[4] = 16'h0001;
        lw[5] = 16'h8000; rw[5] = 16'h8000;
        for (int i = 6; i < NF; i++) begin
            lw[i] = 16'($urandom);
            rw[i] = 16'($urandom);
        end
        for (int i = 0; i < NF; i++) md[i] = (i % 5 == 1) || (i % 5 == 2) || (i % 5 == 4);
        mode_in = md[0];

        // R8: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        prev_k = -1; prev_h = 1; prev_j = 0;
        chk("R8", "ws_out", ws_out, 1'b0);
        chk("R8", "l_pos", l_pos, 1'b0);
        chk("R8", "l_neg", l_neg, 1'b0);
        chk("R8", "r_pos", r_pos, 1'b0);
        chk("R8", "r_neg", r_neg, 1'b0);
        chk("R8", "min_flag", min_flag, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < 40; i++) step(-1, 1, 0, 1'b0);

        for (int k = 0; k < NF; k++) begin
            for (int h = 0; h < 2; h++) begin
                for (int j = 0; j < 32; j++) begin
                    logic [15:0] w;
                    logic sd;
                    w = h ? rw[k] : lw[k];
                    // R1: bits outside the sample window carry random garbage.
                    sd = (j >= 1 && j <= 16) ? w[16-j] : 1'($urandom_range(0, 1));
                    step(k, h, j, sd);
                end
            end
        end
        step(NF - 1, 1, 31, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule